// File: doc/BRIEF.md
# Dynamic Duty Override Controller

The block runs beside the output-voltage loop of a switching power stage. It takes one digitized sample of the sensed output voltage per switching cycle and compares it with a set of bands around the regulation reference. From that comparison it issues a duty-override command: follow the loop, boost duty, cut duty, or force the minimum duty. The bands have hysteresis, so a command ends at a different level from the one that started it. This stops the block from toggling near a single threshold.

At each power-up the block chooses one of two band sets. During the first switching cycle it holds an external pin low. It releases the pin when the second cycle starts. A fixed delay later it reads a comparator on that pin. The choice then holds until the next under-voltage lockout. When the output stays above a fault limit for several cycles in a row, the block also latches an over-voltage fault request.

Top module: `dyn_duty_override`

## Requirements
- R1: While `rst_ni` is low or `uvlo_i` is high, all state clears. The values are `mode_o`=0, `fault_o`=0, `set_valid_o`=0, `set_sel_o`=0 and `pull_down_o`=1. After the release, each output changes only on a clock edge.
- R2: `pull_down_o` stays high from the release of UVLO through the first cycle. The first cycle starts at the first `strobe_i`. `pull_down_o` drops on the edge that takes the second `strobe_i`. It stays low until UVLO.
- R3: `pin_cmp_i` is sampled on the SAMPLE_DLY-th clock edge after the edge that took the second strobe. If it is 1 there, set 0 is chosen (`set_sel_o`=0). If it is 0, set 1 is chosen (`set_sel_o`=1). `set_valid_o` rises on that same edge. The choice then holds until UVLO, and later comparator values are ignored.
- R4: Each threshold code is REF_CODE + (REF_CODE·p+500)/1000, or REF_CODE − (REF_CODE·|p|+500)/1000 for a negative p. Here p is in tenths of a percent and the division is integer division. Set 0 uses: floor level +100, cut level +57, over-voltage release +29, under-voltage release −29, boost level −57, fault limit +150. Set 1 uses: floor level +150, cut level +100, over-voltage release +57, under-voltage release −57, boost level −100, fault limit +200.
- R5: `mode_o` encodes 0 as follow, 1 as boost, 2 as cut and 3 as floor (minimum duty). The mode is re-evaluated only on a clock edge with `strobe_i`=1, and only after `set_valid_o`=1. Before that it stays 0.
- R6: From follow, a sample below the boost level gives boost. Boost holds while the sample is at or below the under-voltage release level. Boost ends, giving follow, once the sample exceeds that level.
- R7: A sample at or above the cut level and below the floor level gives cut. Cut holds while the sample stays at or above the over-voltage release level.
- R8: A sample at or above the floor level gives floor from any mode. Floor holds, without falling back to cut, until the sample is below the over-voltage release level.
- R9: Over-voltage modes have priority. A sample that reaches the cut level while in boost gives cut. On leaving cut or floor, a sample below the boost level goes straight to boost.
- R10: While `loop_settled_i`=1, an evaluation ends boost, giving follow, and boost cannot be entered.
- R11: `fault_o` rises on the evaluating edge of the OVP_CYCLES-th consecutive evaluated strobe whose sample is strictly above the fault limit. Any evaluated sample at or below the limit restarts the count.
- R12: `fault_o` stays latched until a clock edge with `fault_clr_i`=1 or UVLO. A clear also restarts the count, and it wins over a qualifying strobe on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uvlo_i | input | 1 | Under-voltage lockout, synchronous clear |
| strobe_i | input | 1 | One-clock pulse at the start of each switching cycle; `sample_i` is valid with it |
| sample_i | input | SAMPLE_W | Digitized output-voltage sample |
| pin_cmp_i | input | 1 | Comparator on the set-select pin (1 = above its threshold) |
| loop_settled_i | input | 1 | Loop compensation has reached its steady-state level |
| fault_clr_i | input | 1 | Clears the latched fault request |
| pull_down_o | output | 1 | Holds the set-select pin low |
| set_valid_o | output | 1 | The band set has been chosen |
| set_sel_o | output | 1 | Chosen band set (0 or 1) |
| mode_o | output | 2 | Duty-override command |
| fault_o | output | 1 | Latched over-voltage fault request |

## Verification
The bench builds the block with SAMPLE_W=12, REF_CODE=2048 and OVP_CYCLES=4. It uses SAMPLE_DLY=16 in place of the production 1250. With the short delay, the selection window, strobes that land inside it and a comparator change in the middle of it can all be reached in a few dozen cycles. With the reference at 2048, every band edge falls on a distinct integer code. The bench drives samples exactly on each edge and one code to either side, in both sets. It also drives runs of three, four and more over-limit samples to exercise fault qualification.

// File: rtl/dyn_pkg.sv
package dyn_pkg;

  typedef enum logic [1:0] {
    MODE_FOLLOW = 2'd0,
    MODE_BOOST  = 2'd1,
    MODE_CUT    = 2'd2,
    MODE_FLOOR  = 2'd3
  } dyn_mode_e;

  localparam int unsigned THR_N     = 6;
  localparam int unsigned THR_FLOOR = 0;
  localparam int unsigned THR_CUT   = 1;
  localparam int unsigned THR_OREL  = 2;
  localparam int unsigned THR_UREL  = 3;
  localparam int unsigned THR_BOOST = 4;
  localparam int unsigned THR_FAULT = 5;

  // offset from the reference in tenths of a percent
  function automatic int band_tenths(int set_idx, int k);
    case (k)
      THR_FLOOR: return (set_idx != 0) ? 150  : 100;
      THR_CUT:   return (set_idx != 0) ? 100  : 57;
      THR_OREL:  return (set_idx != 0) ? 57   : 29;
      THR_UREL:  return (set_idx != 0) ? -57  : -29;
      THR_BOOST: return (set_idx != 0) ? -100 : -57;
      default:   return (set_idx != 0) ? 200  : 150;
    endcase
  endfunction

  function automatic int scaled_code(int ref_code, int tenths);
    int mag;
    mag = (tenths < 0) ? -tenths : tenths;
    mag = (ref_code * mag + 500) / 1000;
    return (tenths < 0) ? ref_code - mag : ref_code + mag;
  endfunction

endpackage

// File: rtl/dyn_set_select.sv
module dyn_set_select #(
  parameter int unsigned SAMPLE_DLY = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uvlo_i,
  input  logic strobe_i,
  input  logic pin_cmp_i,
  output logic pull_down_o,
  output logic set_valid_o,
  output logic set_sel_o
);

  localparam int unsigned DW = $clog2(SAMPLE_DLY + 1);

  logic [1:0]    cyc_q;
  logic          arm_q;
  logic [DW-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q       <= '0;
      arm_q       <= 1'b0;
      dly_q       <= '0;
      pull_down_o <= 1'b1;
      set_valid_o <= 1'b0;
      set_sel_o   <= 1'b0;
    end else if (uvlo_i) begin
      cyc_q       <= '0;
      arm_q       <= 1'b0;
      dly_q       <= '0;
      pull_down_o <= 1'b1;
      set_valid_o <= 1'b0;
      set_sel_o   <= 1'b0;
    end else begin
      if (arm_q) begin
        if (dly_q == DW'(SAMPLE_DLY - 1)) begin
          arm_q       <= 1'b0;
          set_valid_o <= 1'b1;
          set_sel_o   <= ~pin_cmp_i;
        end else begin
          dly_q <= dly_q + 1'b1;
        end
      end
      if (strobe_i) begin
        if (cyc_q == 2'd0) begin
          cyc_q <= 2'd1;
        end else if (cyc_q == 2'd1) begin
          cyc_q       <= 2'd2;
          arm_q       <= 1'b1;
          dly_q       <= '0;
          pull_down_o <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dyn_band_table.sv
module dyn_band_table
  import dyn_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned REF_CODE = 2048
) (
  input  logic                           set_sel_i,
  output logic [THR_N-1:0][SAMPLE_W-1:0] thr_o
);

  logic [1:0][THR_N-1:0][SAMPLE_W-1:0] lut;

  for (genvar s = 0; s < 2; s++) begin : g_set
    for (genvar k = 0; k < THR_N; k++) begin : g_thr
      assign lut[s][k] = SAMPLE_W'(scaled_code(int'(REF_CODE), band_tenths(s, k)));
    end
  end

  assign thr_o = set_sel_i ? lut[1] : lut[0];

endmodule

// File: rtl/dyn_mode_fsm.sv
module dyn_mode_fsm
  import dyn_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           uvlo_i,
  input  logic                           eval_i,
  input  logic [SAMPLE_W-1:0]            sample_i,
  input  logic                           settled_i,
  input  logic [THR_N-1:0][SAMPLE_W-1:0] thr_i,
  output dyn_mode_e                      mode_o
);

  dyn_mode_e mode_d;
  logic      hi_floor, hi_cut, ov_clear, uv_enter, uv_stay;
  dyn_mode_e rest_mode;

  always_comb begin
    hi_floor  = sample_i >= thr_i[THR_FLOOR];
    hi_cut    = sample_i >= thr_i[THR_CUT];
    ov_clear  = sample_i <  thr_i[THR_OREL];
    uv_enter  = (sample_i <  thr_i[THR_BOOST]) && !settled_i;
    uv_stay   = (sample_i <= thr_i[THR_UREL])  && !settled_i;
    rest_mode = uv_enter ? MODE_BOOST : MODE_FOLLOW;
    unique case (mode_o)
      MODE_FOLLOW: mode_d = hi_floor ? MODE_FLOOR : (hi_cut ? MODE_CUT : rest_mode);
      MODE_BOOST:  mode_d = hi_floor ? MODE_FLOOR :
                            (hi_cut ? MODE_CUT : (uv_stay ? MODE_BOOST : MODE_FOLLOW));
      MODE_CUT:    mode_d = hi_floor ? MODE_FLOOR : (ov_clear ? rest_mode : MODE_CUT);
      MODE_FLOOR:  mode_d = ov_clear ? rest_mode : MODE_FLOOR;
      default:     mode_d = MODE_FOLLOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_o <= MODE_FOLLOW;
    else if (uvlo_i)  mode_o <= MODE_FOLLOW;
    else if (eval_i)  mode_o <= mode_d;
  end

endmodule

// File: rtl/dyn_ovp_qual.sv
module dyn_ovp_qual #(
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned OVP_CYCLES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                uvlo_i,
  input  logic                eval_i,
  input  logic                clr_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] limit_i,
  output logic                fault_o
);

  localparam int unsigned CW = $clog2(OVP_CYCLES + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      fault_o <= 1'b0;
    end else if (uvlo_i || clr_i) begin
      run_q   <= '0;
      fault_o <= 1'b0;
    end else if (eval_i) begin
      if (sample_i > limit_i) begin
        if (run_q >= CW'(OVP_CYCLES - 1)) fault_o <= 1'b1;
        else                              run_q   <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

endmodule

// File: rtl/dyn_duty_override.sv
module dyn_duty_override
  import dyn_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned REF_CODE   = 2048,
  parameter int unsigned SAMPLE_DLY = 1250,
  parameter int unsigned OVP_CYCLES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                uvlo_i,
  input  logic                strobe_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                pin_cmp_i,
  input  logic                loop_settled_i,
  input  logic                fault_clr_i,
  output logic                pull_down_o,
  output logic                set_valid_o,
  output logic                set_sel_o,
  output logic [1:0]          mode_o,
  output logic                fault_o
);

  logic [THR_N-1:0][SAMPLE_W-1:0] thr;
  logic                           eval;
  dyn_mode_e                      mode_q;

  assign eval = strobe_i && set_valid_o;

  dyn_set_select #(.SAMPLE_DLY(SAMPLE_DLY)) i_set_select (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .uvlo_i      (uvlo_i),
    .strobe_i    (strobe_i),
    .pin_cmp_i   (pin_cmp_i),
    .pull_down_o (pull_down_o),
    .set_valid_o (set_valid_o),
    .set_sel_o   (set_sel_o)
  );

  dyn_band_table #(.SAMPLE_W(SAMPLE_W), .REF_CODE(REF_CODE)) i_band_table (
    .set_sel_i (set_sel_o),
    .thr_o     (thr)
  );

  dyn_mode_fsm #(.SAMPLE_W(SAMPLE_W)) i_mode_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uvlo_i    (uvlo_i),
    .eval_i    (eval),
    .sample_i  (sample_i),
    .settled_i (loop_settled_i),
    .thr_i     (thr),
    .mode_o    (mode_q)
  );

  dyn_ovp_qual #(.SAMPLE_W(SAMPLE_W), .OVP_CYCLES(OVP_CYCLES)) i_ovp_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .uvlo_i   (uvlo_i),
    .eval_i   (eval),
    .clr_i    (fault_clr_i),
    .sample_i (sample_i),
    .limit_i  (thr[THR_FAULT]),
    .fault_o  (fault_o)
  );

  assign mode_o = mode_q;

endmodule

// File: rtl/dyn_duty_override_chk.sv
module dyn_duty_override_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uvlo_i,
  input logic       strobe_i,
  input logic       fault_clr_i,
  input logic       pull_down_o,
  input logic       set_valid_o,
  input logic       set_sel_o,
  input logic [1:0] mode_o,
  input logic       fault_o
);

  // R1
  uvlo_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (pull_down_o && !set_valid_o && !fault_o && mode_o == 2'd0));

  // R5
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !uvlo_i) |=> $stable(mode_o));

  // R5
  mode_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_valid_o |-> mode_o == 2'd0);

  // R3
  set_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_valid_o && !uvlo_i) |=> (set_valid_o && $stable(set_sel_o)));

  // R2
  pin_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_valid_o |-> !pull_down_o);

  // R11
  fault_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(strobe_i));

  // R12
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i && !uvlo_i) |=> fault_o);

  // R12
  fault_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_clr_i |=> !fault_o);

endmodule

bind dyn_duty_override dyn_duty_override_chk i_dyn_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .uvlo_i      (uvlo_i),
  .strobe_i    (strobe_i),
  .fault_clr_i (fault_clr_i),
  .pull_down_o (pull_down_o),
  .set_valid_o (set_valid_o),
  .set_sel_o   (set_sel_o),
  .mode_o      (mode_o),
  .fault_o     (fault_o)
);

// File: tb/test_dyn_duty_override.sv
`timescale 1ns/1ps
module test_dyn_duty_override;

  localparam int W    = 12;
  localparam int REF  = 2048;
  localparam int DLY  = 16;
  localparam int OVPN = 4;

  logic clk = 1'b0, rst_n = 1'b0, uvlo = 1'b1, strobe = 1'b0, pin = 1'b0;
  logic settled = 1'b0, fclr = 1'b0;
  logic [W-1:0] sample = '0;
  logic pd, valid, sel, fault;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dyn_duty_override #(.SAMPLE_W(W), .REF_CODE(REF), .SAMPLE_DLY(DLY), .OVP_CYCLES(OVPN))
  i_dyn_duty_override (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo), .strobe_i(strobe), .sample_i(sample),
    .pin_cmp_i(pin), .loop_settled_i(settled), .fault_clr_i(fclr),
    .pull_down_o(pd), .set_valid_o(valid), .set_sel_o(sel), .mode_o(mode), .fault_o(fault)
  );

  // band codes from the requirement formula (R4)
  function automatic int code_of(int t);
    int m;
    m = (t < 0) ? -t : t;
    m = (REF * m + 500) / 1000;
    return (t < 0) ? REF - m : REF + m;
  endfunction

  // which: 0 floor, 1 cut, 2 ov release, 3 uv release, 4 boost, 5 fault
  function automatic int band(int s, int which);
    int s0 [6] = '{100, 57, 29, -29, -57, 150};
    int s1 [6] = '{150, 100, 57, -57, -100, 200};
    return code_of(s ? s1[which] : s0[which]);
  endfunction

  // reference model
  int m_cyc, m_dly, m_mode, m_run;
  bit m_arm, m_pd, m_valid, m_sel, m_fault;

  function automatic int model_next(int cur, int s, int st, bit sett);
    bit want;
    if (s >= band(st, 0)) return 3;
    if (cur >= 2 && s >= band(st, 2)) return cur;
    if (s >= band(st, 1)) return 2;
    want = (s < band(st, 4)) || (cur == 1 && s <= band(st, 3));
    if (sett) want = 0;
    return want ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || uvlo) begin
      m_cyc <= 0; m_dly <= 0; m_mode <= 0; m_run <= 0;
      m_arm <= 0; m_pd <= 1; m_valid <= 0; m_sel <= 0; m_fault <= 0;
    end else begin
      if (m_arm) begin
        if (m_dly == DLY - 1) begin
          m_arm <= 0; m_valid <= 1; m_sel <= !pin;
        end else m_dly <= m_dly + 1;
      end
      if (strobe) begin
        if (m_cyc == 0) m_cyc <= 1;
        else if (m_cyc == 1) begin
          m_cyc <= 2; m_arm <= 1; m_dly <= 0; m_pd <= 0;
        end
        if (m_valid) begin
          m_mode <= model_next(m_mode, int'(sample), int'(m_sel), settled);
          if (int'(sample) > band(int'(m_sel), 5)) begin
            if (m_run + 1 >= OVPN) m_fault <= 1;
            m_run <= m_run + 1;
          end else m_run <= 0;
        end
      end
      if (fclr) begin
        m_fault <= 0; m_run <= 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(mode) == m_mode, "R5 model mode", int'(mode), m_mode);
      check(fault == m_fault, "R11 model fault", int'(fault), int'(m_fault));
      check(pd == m_pd, "R2 model pull_down", int'(pd), int'(m_pd));
      check(valid == m_valid, "R3 model set_valid", int'(valid), int'(m_valid));
      check(sel == m_sel, "R3 model set_sel", int'(sel), int'(m_sel));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic step(input int s, input int exp_mode, input string tag);
    @(posedge clk); #1;
    strobe = 1'b1; sample = W'(s);
    @(posedge clk); #1;
    strobe = 1'b0;
    @(negedge clk);
    check(int'(mode) == exp_mode, tag, int'(mode), exp_mode);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    #9 rst_n = 1'b1;
    idle(3);
    check(pd == 1 && valid == 0 && fault == 0 && mode == 0, "R1 uvlo state", int'(pd), 1);
    uvlo = 1'b0;
    idle(2);
    check(pd == 1, "R2 pin held before first cycle", int'(pd), 1);
    pin = 1'b1;
    step(2048, 0, "R5 first cycle");
    check(pd == 1, "R2 pin held in first cycle", int'(pd), 1);
    step(1900, 0, "R5 second cycle");
    check(pd == 0, "R2 pin released", int'(pd), 0);
    check(valid == 0, "R3 not yet sampled", int'(valid), 0);
    step(1900, 0, "R5 no evaluation before set chosen");
    idle(20);
    check(valid == 1 && sel == 0, "R3 set 0 chosen", int'(sel), 0);
    pin = 1'b0;
    idle(3);
    check(sel == 0, "R3 later pin change ignored", int'(sel), 0);

    // set 0: floor 2253 cut 2165 orel 2107 urel 1989 boost 1931 fault 2355
    step(1930, 1, "R6 boost entry");
    step(1989, 1, "R6 boost held at release level");
    step(1990, 0, "R6 boost exit");
    step(1931, 0, "R4 boost level not below");
    step(2165, 2, "R7 cut entry at level");
    step(2107, 2, "R7 cut held at release");
    step(2106, 0, "R7 cut exit");
    step(2252, 2, "R4 below floor gives cut");
    step(2253, 3, "R8 floor entry");
    step(2165, 3, "R8 floor no downgrade");
    step(1900, 1, "R9 floor exit to boost");
    step(2170, 2, "R9 over-voltage priority");
    step(2000, 0, "R7 exit to follow");
    step(1900, 1, "R6 boost again");
    settled = 1'b1;
    step(1900, 0, "R10 settled ends boost");
    step(1900, 0, "R10 settled blocks boost");
    settled = 1'b0;
    step(2048, 0, "R5 follow");

    // fault qualification, limit 2355
    step(2356, 3, "R11 over limit 1");
    step(2356, 3, "R11 over limit 2");
    step(2356, 3, "R11 over limit 3");
    check(fault == 0, "R11 no fault after 3", int'(fault), 0);
    step(2355, 3, "R11 at limit restarts count");
    step(2356, 3, "R11 run 1");
    step(2356, 3, "R11 run 2");
    step(2356, 3, "R11 run 3");
    check(fault == 0, "R11 restarted count", int'(fault), 0);
    step(2356, 3, "R11 run 4");
    check(fault == 1, "R11 fault after 4", int'(fault), 1);
    step(2048, 0, "R5 follow after floor");
    check(fault == 1, "R12 fault latched", int'(fault), 1);
    fclr = 1'b1;
    idle(1);
    fclr = 1'b0;
    @(negedge clk);
    check(fault == 0, "R12 fault cleared", int'(fault), 0);

    // lockout and reselect
    step(1900, 1, "R6 boost before lockout");
    @(negedge clk);
    uvlo = 1'b1;
    idle(2);
    check(pd == 1 && valid == 0 && mode == 0 && sel == 0, "R1 lockout clears", int'(mode), 0);
    uvlo = 1'b0;
    pin = 1'b1;
    step(2048, 0, "R2 first cycle again");
    step(2048, 0, "R2 second cycle again");
    idle(4);
    pin = 1'b0;
    idle(20);
    check(valid == 1 && sel == 1, "R3 set 1 chosen at sample edge", int'(sel), 1);

    // set 1: floor 2355 cut 2253 orel 2165 urel 1931 boost 1843 fault 2458
    step(1900, 0, "R4 set 1 no boost at 1900");
    step(1842, 1, "R4 set 1 boost entry");
    step(1931, 1, "R6 set 1 boost held");
    step(1932, 0, "R6 set 1 boost exit");
    step(2253, 2, "R7 set 1 cut");
    step(2355, 3, "R8 set 1 floor");
    step(2164, 0, "R8 set 1 floor exit");
    for (int i = 0; i < 4; i++) step(2458, 3, "R4 set 1 at limit");
    check(fault == 0, "R11 set 1 at limit no fault", int'(fault), 0);
    for (int i = 0; i < 4; i++) step(2459, 3, "R11 set 1 over limit");
    check(fault == 1, "R11 set 1 fault", int'(fault), 1);
    fclr = 1'b1;
    step(2459, 3, "R12 clear wins over strobe");
    fclr = 1'b0;
    check(fault == 0, "R12 clear wins", int'(fault), 0);

    idle(2);
    done = 1;
    summary();
    $finish;
  end

endmodule